// File: doc/BRIEF.md
# Byte-Lane Writable Dual-Port Word Memory

This block is a behavioural dual-port memory of 2048 words, each 16 bits wide, so 32 kilobits in all. One port only reads and the other only writes, and each runs on its own clock. Its contents can be preloaded through a parameter that holds the whole image. The read port registers the word at its address on its active clock edge, but only while its read enable is high. The write port takes a two-bit lane enable. A decoder turns that enable into a write strobe, a byte-mode flag and an upper/lower lane select. As a result, a single write updates either the whole word or exactly one of its two bytes.

Each port has a parameter that makes it act on the falling edge of its clock instead of the rising edge. The block has no output register stage and no reset. A read that lands on the same edge as a write to the same address returns the word as it was before that write.

Top module: `lanewr_dpram`

## Requirements
- R1: The initial content of word i is bits [16*i+15 : 16*i] of the image parameter, for every address from 0 to 2047. The address is 11 bits wide.
- R2: When the lane enable is 2'b11, a write stores all 16 data bits at the write address.
- R3: When the lane enable is 2'b10 (bit 1 is the upper lane), only bits [15:8] of the addressed word take the write data bits [15:8]. Bits [7:0] keep their value.
- R4: When the lane enable is 2'b01 (bit 0 is the lower lane), only bits [7:0] of the addressed word take the write data bits [7:0]. Bits [15:8] keep their value.
- R5: When the lane enable is 2'b00, nothing in the memory changes.
- R6: The read data takes the addressed word on the active edge of the read clock while the read enable is 1. While the read enable is 0 it holds its value, even if the read address changes.
- R7: A read on the same edge as a write to the same address returns the word as it was before that write. A later read returns the new word.
- R8: When a port's clock-invert parameter is 1, that port acts only on the falling edge of its clock and ignores the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Read port clock |
| rd_en | input | 1 | Read enable, which is also the read port chip select |
| rd_addr | input | 11 | Read word address |
| rd_data | output | 16 | Registered read word |
| clk_b | input | 1 | Write port clock |
| wr_lanes | input | 2 | Lane enable: bit 1 is the upper byte, bit 0 is the lower byte |
| wr_addr | input | 11 | Write word address |
| wr_din | input | 16 | Write data |

## Verification
The hardest case to reach from the ports is a partial write whose effect can only be seen later, through the read port. The other byte must be shown to survive, and a read colliding with the write on the same edge must still return the old word. The vector table places a single-lane write and a same-address read on one edge, checks that this read gives the old word, and then reads the address again with the write idle to expose the merged result. A second instance with both clocks inverted is driven on the opposite edge to show that the rising edge does nothing.

// File: rtl/lanewr_pkg.sv
package lanewr_pkg;

    // The lane enable is two bits wide, so a word always has exactly two byte lanes.
    localparam int LANES = 2;

    // Write controls decoded from the lane enable.
    typedef struct packed {
        logic chip_sel;   // port B chip select
        logic wr_stb;     // write strobe
        logic byte_mode;  // exactly one lane is written
        logic upper_sel;  // 1: upper byte, 0: lower byte
    } wr_ctrl_t;

    function automatic wr_ctrl_t decode_lanes(input logic [LANES-1:0] lanes);
        wr_ctrl_t c;
        c.chip_sel  = lanes[1] | lanes[0];
        c.wr_stb    = lanes[1] | lanes[0];
        c.byte_mode = lanes[1] ^ lanes[0];
        c.upper_sel = lanes[1];
        return c;
    endfunction

    // Decides whether lane `idx` of the word takes the new data.
    function automatic logic lane_taken(input wr_ctrl_t c, input int idx);
        if (!c.wr_stb) return 1'b0;
        if (!c.byte_mode) return 1'b1;
        return (idx == 1) ? c.upper_sel : !c.upper_sel;
    endfunction

endpackage

// File: rtl/lanewr_decoder.sv
module lanewr_decoder
    import lanewr_pkg::*;
(
    input  logic [LANES-1:0] lanes,
    output wr_ctrl_t         ctrl
);
    always_comb begin
        ctrl = decode_lanes(lanes);
    end
endmodule

// File: rtl/lanewr_store.sv
module lanewr_store
    import lanewr_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int LANE_W  = 8,
    parameter bit CLK_INV = 1'b0,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  wr_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] old_word
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] merged;
    logic              do_write;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT_IMAGE[i*DATA_W +: DATA_W];
        end
    end

    assign old_word = mem[wr_addr];
    assign rd_word  = mem[rd_addr];
    assign do_write = ctrl.chip_sel & ctrl.wr_stb;

    // Each lane takes either the new data or its current value.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            merged[l*LANE_W +: LANE_W] = lane_taken(ctrl, l) ?
                wr_din[l*LANE_W +: LANE_W] : old_word[l*LANE_W +: LANE_W];
        end
    end

    if (CLK_INV) begin : g_fall
        always_ff @(negedge clk) begin
            if (do_write) mem[wr_addr] <= merged;
        end
    end else begin : g_rise
        always_ff @(posedge clk) begin
            if (do_write) mem[wr_addr] <= merged;
        end
    end
endmodule

// File: rtl/lanewr_rdreg.sv
module lanewr_rdreg #(
    parameter int DATA_W  = 16,
    parameter bit CLK_INV = 1'b0
) (
    input  logic              clk,
    input  logic              cs,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] q
);
    if (CLK_INV) begin : g_fall
        always_ff @(negedge clk) begin
            if (cs) q <= word_in;
        end
    end else begin : g_rise
        always_ff @(posedge clk) begin
            if (cs) q <= word_in;
        end
    end
endmodule

// File: rtl/lanewr_dpram.sv
module lanewr_dpram
    import lanewr_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int LANE_W   = 8,
    parameter bit CLKA_INV = 1'b0,
    parameter bit CLKB_INV = 1'b0,
    localparam int DATA_W  = LANES * LANE_W,
    localparam int DEPTH   = 1 << ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk_a,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clk_b,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_din
);
    wr_ctrl_t          b_ctrl;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] old_word;

    lanewr_decoder u_dec (
        .lanes (wr_lanes),
        .ctrl  (b_ctrl)
    );

    lanewr_store #(
        .ADDR_W     (ADDR_W),
        .LANE_W     (LANE_W),
        .CLK_INV    (CLKB_INV),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_store (
        .clk      (clk_b),
        .ctrl     (b_ctrl),
        .wr_addr  (wr_addr),
        .wr_din   (wr_din),
        .rd_addr  (rd_addr),
        .rd_word  (store_word),
        .old_word (old_word)
    );

    // Port A is read-only: its chip select is the read enable.
    lanewr_rdreg #(
        .DATA_W  (DATA_W),
        .CLK_INV (CLKA_INV)
    ) u_rd (
        .clk     (clk_a),
        .cs      (rd_en),
        .word_in (store_word),
        .q       (rd_data)
    );
endmodule

// File: rtl/lanewr_dpram_chk.sv
module lanewr_dpram_chk #(
    parameter int ADDR_W   = 11,
    parameter int LANE_W   = 8,
    parameter bit CLKA_INV = 1'b0,
    parameter bit CLKB_INV = 1'b0,
    localparam int DATA_W  = 2 * LANE_W
) (
    input logic              clk_a,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              clk_b,
    input logic [1:0]        wr_lanes,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_din,
    input logic [DATA_W-1:0] store_word,
    input logic [DATA_W-1:0] old_word
);
    logic ck_a, ck_b;
    logic [1:0] arm_a = 2'b00;
    logic [1:0] arm_b = 2'b00;

    assign ck_a = CLKA_INV ? ~clk_a : clk_a;
    assign ck_b = CLKB_INV ? ~clk_b : clk_b;

    always_ff @(posedge ck_a) arm_a <= {arm_a[0], 1'b1};
    always_ff @(posedge ck_b) arm_b <= {arm_b[0], 1'b1};

    // R2: a full-lane write lands whole
    p_full_word_r2: assert property (@(posedge ck_b) disable iff (!arm_b[1])
        ($past(wr_lanes) == 2'b11 && wr_addr == $past(wr_addr))
        |-> old_word == $past(wr_din));

    // R3: an upper-lane write keeps the lower byte
    p_upper_only_r3: assert property (@(posedge ck_b) disable iff (!arm_b[1])
        ($past(wr_lanes) == 2'b10 && wr_addr == $past(wr_addr))
        |-> (old_word[DATA_W-1:LANE_W] == $past(wr_din[DATA_W-1:LANE_W])
             && old_word[LANE_W-1:0] == $past(old_word[LANE_W-1:0])));

    // R4: a lower-lane write keeps the upper byte
    p_lower_only_r4: assert property (@(posedge ck_b) disable iff (!arm_b[1])
        ($past(wr_lanes) == 2'b01 && wr_addr == $past(wr_addr))
        |-> (old_word[LANE_W-1:0] == $past(wr_din[LANE_W-1:0])
             && old_word[DATA_W-1:LANE_W] == $past(old_word[DATA_W-1:LANE_W])));

    // R5: no lanes, no change
    p_idle_keep_r5: assert property (@(posedge ck_b) disable iff (!arm_b[1])
        ($past(wr_lanes) == 2'b00 && wr_addr == $past(wr_addr))
        |-> old_word == $past(old_word));

    // R6: the read register holds while the port is deselected
    p_read_hold_r6: assert property (@(posedge ck_a) disable iff (!arm_a[1])
        !rd_en |=> $stable(rd_data));

    // R7: a read captures the word as it stood before the edge
    p_read_old_r7: assert property (@(posedge ck_a) disable iff (!arm_a[1])
        rd_en |=> rd_data == $past(store_word));
endmodule

bind lanewr_dpram lanewr_dpram_chk #(
    .ADDR_W   (ADDR_W),
    .LANE_W   (LANE_W),
    .CLKA_INV (CLKA_INV),
    .CLKB_INV (CLKB_INV)
) u_chk (
    .clk_a      (clk_a),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .clk_b      (clk_b),
    .wr_lanes   (wr_lanes),
    .wr_addr    (wr_addr),
    .wr_din     (wr_din),
    .store_word (store_word),
    .old_word   (old_word)
);

// File: tb/sim_lanewr_dpram.sv
`timescale 1ns/1ps
module sim_lanewr_dpram;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    function automatic logic [DW-1:0] seed_word(input int i);
        logic [31:0] v;
        v = i * 32'h9E37;
        return v[DW-1:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [DEPTH*DW-1:0] build_img();
        logic [DEPTH*DW-1:0] img;
        for (int i = 0; i < DEPTH; i++) img[i*DW +: DW] = seed_word(i);
        return img;
    endfunction

    localparam logic [DEPTH*DW-1:0] IMG = build_img();

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    // Main instance
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [1:0]    wr_lanes = 2'b00;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_din = '0;

    lanewr_dpram #(.INIT_IMAGE(IMG)) u0 (
        .clk_a(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .clk_b(clk), .wr_lanes(wr_lanes), .wr_addr(wr_addr), .wr_din(wr_din)
    );

    // Instance with both clocks inverted
    logic          rd_en1 = 1'b0;
    logic [AW-1:0] rd_addr1 = '0;
    logic [DW-1:0] rd_data1;
    logic [1:0]    wr_lanes1 = 2'b00;
    logic [AW-1:0] wr_addr1 = '0;
    logic [DW-1:0] wr_din1 = '0;

    lanewr_dpram #(.CLKA_INV(1'b1), .CLKB_INV(1'b1), .INIT_IMAGE(IMG)) u1 (
        .clk_a(clk), .rd_en(rd_en1), .rd_addr(rd_addr1), .rd_data(rd_data1),
        .clk_b(clk), .wr_lanes(wr_lanes1), .wr_addr(wr_addr1), .wr_din(wr_din1)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_name(input logic [3:0] c);
        case (c)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R?";
        endcase
    endfunction

    // Row: tag, lanes, write address, write data, read enable, read address
    typedef struct packed {
        logic [3:0]    tag;
        logic [1:0]    lanes;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          re;
        logic [AW-1:0] raddr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        {4'd1, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd0},
        {4'd1, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd2047},
        {4'd2, 2'b11, 11'd5,    16'h1234, 1'b1, 11'd3},
        {4'd2, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd5},
        {4'd6, 2'b10, 11'd6,    16'hABCD, 1'b0, 11'd6},
        {4'd3, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd6},
        {4'd7, 2'b01, 11'd7,    16'h5566, 1'b1, 11'd7},
        {4'd4, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd7},
        {4'd6, 2'b00, 11'd8,    16'hFFFF, 1'b1, 11'd1},
        {4'd5, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd8},
        {4'd7, 2'b11, 11'd9,    16'h0F0F, 1'b1, 11'd9},
        {4'd7, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd9},
        {4'd6, 2'b10, 11'd2047, 16'h7788, 1'b0, 11'd2047},
        {4'd3, 2'b00, 11'd0,    16'h0000, 1'b1, 11'd2047}
    };

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] exp_q;

    // Model of one write: bit 1 is the upper lane, bit 0 the lower lane
    task automatic model_write(input logic [1:0] ln, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (ln[1]) mdl[a][15:8] = d[15:8];
        if (ln[0]) mdl[a][7:0]  = d[7:0];
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = seed_word(i);
        exp_q = '0;

        // Table walk: drive on falling edge, design acts on rising edge
        for (int s = 0; s <= NV; s++) begin
            @(negedge clk);
            if (s > 0) check(tag_name(TBL[s-1].tag), rd_data, exp_q);
            if (s < NV) begin
                rd_en    = TBL[s].re;
                rd_addr  = TBL[s].raddr;
                wr_lanes = TBL[s].lanes;
                wr_addr  = TBL[s].waddr;
                wr_din   = TBL[s].wdata;
                if (TBL[s].re) exp_q = mdl[TBL[s].raddr];
                model_write(TBL[s].lanes, TBL[s].waddr, TBL[s].wdata);
            end
        end

        // R4: lower-lane write at the top address, then read back
        wr_lanes = 2'b01; wr_addr = 11'd2047; wr_din = 16'h3C96; rd_en = 1'b0;
        @(negedge clk);
        wr_lanes = 2'b00; rd_en = 1'b1; rd_addr = 11'd2047;
        @(negedge clk);
        check("R4", rd_data, {16'h7788 & 16'hFF00} | {8'h00, 8'h96});
        rd_en = 1'b0;

        // R8: inverted instance acts on the falling edge only
        @(posedge clk); #0.5;
        wr_lanes1 = 2'b11; wr_addr1 = 11'd20; wr_din1 = 16'hC0DE;
        rd_en1 = 1'b1; rd_addr1 = 11'd20;
        @(negedge clk); #0.5;
        check("R8", rd_data1, seed_word(20));
        wr_lanes1 = 2'b00;
        @(posedge clk); #0.5;
        check("R8", rd_data1, seed_word(20));
        @(negedge clk); #0.5;
        check("R8", rd_data1, 16'hC0DE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule